// File: doc/BRIEF.md
# DRAM Location to Host Address Scatter

This block turns a decoded DRAM location (DIMM select, master rank, slave rank, row, column, bank and bank group) into a 40-bit host-side physical address. Each location bit is placed by a 5-bit position code. Software loads these codes into three 64-bit map words through a small write port. The low fifteen row bits always land on a fixed window of the output.

The decode of a code is not contiguous. Small codes reach output bits 5 to 15, and larger codes jump to output bits 31 to 39. The number of master-rank, slave-rank and upper-row bits that take part comes from configuration counts, and each count enables a chain of bits that ends at the least significant bit of its group. A code that falls outside the legal range, in a field that is enabled, rejects the request. The result is registered, one cycle after the request.

Top module: `addr_scatter`

## Requirements
- R1: A code value k from 0 to 10 places its bit at output bit k+5. A value k from 11 to 19 places it at output bit k+20.
- R2: Row bits 14..0 appear at output bits 30..16 unchanged for every accepted request, whatever the codes and counts.
- R3: Codes are 5-bit fields of the map words. Bit 0 is the most significant bit of each word, and a field is named by the bit it starts at.
  - Word 0: DIMM select at 33, M0 at 38, M1 at 43, R17 at 49, R16 at 54, R15 at 59.
  - Word 1: S0 at 3, S1 at 11, S2 at 19, C3 at 30, C4 at 35, C5 at 43, C6 at 51, C7 at 59.
  - Word 2: C8 at 3, C9 at 11, B0 at 19, B1 at 27, BG0 at 43, BG1 at 51.
- R4: The master-rank count enables a chain of bits. A count of 0 places no master-rank bit, a count of 1 places M1 only, and a count of 2 or more places M0 and M1. The master-rank input holds M0 in its upper bit.
- R5: The slave-rank and extra-row counts work the same way.
  - Slave rank: a count of 1 places S2, 2 places S1 and S2, 3 places S0, S1 and S2. The input holds S0 in its upper bit.
  - Extra row: a count of 1 places R15, 2 places R16 and R15, 3 places R17, R16 and R15.
  - Row bits 17..15 that are not enabled never reach the output.
- R6: The DIMM select bit is placed only while the two-DIMM flag is high.
- R7: The bank input is ordered B0, B1, B2, BG0, BG1 from bit 4 down to bit 0, and the column input holds C9 in bit 6 down to C3 in bit 0. B2 never reaches the output, and the word 2 field at bit 35 has no effect, even when it holds an illegal code.
- R8: All placed bits are OR-combined, so bits that share a position merge. Output bits that no placed bit reaches are zero, and bits 4..0 are always zero.
- R9: When an enabled field holds a code above 19, the result shows out_err high, out_valid low and an all-zero address. The same code in a field that is not enabled causes no error.
- R10: A request presented at a clock edge gives its result at the next edge. Without a request, out_valid and out_err are low.
- R11: A map write changes the result of requests from the next cycle on, and a request in the same cycle as the write uses the previous map. Writes with word select 3 change nothing.
- R12: After reset the outputs are zero and every stored code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Map word write strobe |
| map_wr_sel | input | 2 | Map word select (0..2) |
| map_wr_data | input | 64 | Map word contents |
| cnt_mrank | input | 2 | Number of master-rank bits in use |
| cnt_srank | input | 2 | Number of slave-rank bits in use |
| cnt_xrow | input | 2 | Number of row bits above R14 in use |
| two_dimm | input | 1 | DIMM select takes part when high |
| req_valid | input | 1 | Request strobe |
| req_dimm | input | 1 | DIMM select |
| req_mrank | input | 2 | Master rank, M0 in bit 1 |
| req_srank | input | 3 | Slave rank, S0 in bit 2 |
| req_row | input | 18 | Row R17..R0 |
| req_col | input | 7 | Column C9..C3 |
| req_bank | input | 5 | B0, B1, B2, BG0, BG1 from bit 4 down |
| out_valid | output | 1 | Address result valid |
| out_err | output | 1 | Request rejected for an illegal code |
| out_addr | output | 40 | Host address |

## Verification
The assertions check the per-cycle contract on every cycle:
- the one-cycle latency of an accepted request;
- that a rejection always gives out_err alone with a zero address;
- quiet outputs when there is no request;
- the direct row window;
- zero in bits 4..0.

Where each field lands, the split code space, the count chains, the DIMM gate, B2 being dropped, OR merging and the timing of map writes all depend on the programmed codes. Only the bench's scenarios show them, by comparing against expected positions worked out from the code rules.

// File: rtl/addr_scatter_pkg.sv
package addr_scatter_pkg;

  localparam int CODE_W     = 5;
  localparam int MAP_W      = 64;
  localparam int MAP_CNT    = 3;
  localparam int SEL_W      = $clog2(MAP_CNT + 1);
  localparam int HADDR_W    = 40;
  localparam int POS_W      = $clog2(HADDR_W + 24);
  localparam int NUM_FIELDS = 20;

  localparam int ROW_W      = 18;
  localparam int COL_W      = 7;
  localparam int BANK_W     = 5;
  localparam int MRANK_W    = 2;
  localparam int SRANK_W    = 3;
  localparam int CNT_W      = 2;

  localparam int ROW_DIRECT_W   = 15;
  localparam int ROW_DIRECT_LSB = 16;

  localparam int LOW_CODE_MAX = 10;
  localparam int LOW_BIAS     = 5;
  localparam int HIGH_BIAS    = 20;
  localparam int CODE_MAX     = 19;

  // Lane numbering
  localparam int F_DIMM = 0;
  localparam int F_M0   = 1;
  localparam int F_M1   = 2;
  localparam int F_R17  = 3;
  localparam int F_R16  = 4;
  localparam int F_R15  = 5;
  localparam int F_S0   = 6;
  localparam int F_S1   = 7;
  localparam int F_S2   = 8;
  localparam int F_C3   = 9;
  localparam int F_C9   = 15;
  localparam int F_B0   = 16;
  localparam int F_B1   = 17;
  localparam int F_BG0  = 18;
  localparam int F_BG1  = 19;

  // Map word that holds the code of a lane
  function automatic int field_word(int f);
    if (f <= F_R15)     return 0;
    else if (f <= 13)   return 1;
    else                return 2;
  endfunction

  // Starting bit of the code, counted from the MSB of the word
  function automatic int field_start(int f);
    case (f)
      0: return 33;  1: return 38;  2: return 43;  3: return 49;
      4: return 54;  5: return 59;  6: return 3;   7: return 11;
      8: return 19;  9: return 30;  10: return 35; 11: return 43;
      12: return 51; 13: return 59; 14: return 3;  15: return 11;
      16: return 19; 17: return 27; 18: return 43; default: return 51;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] code_to_pos(logic [CODE_W-1:0] code);
    if (code <= CODE_W'(LOW_CODE_MAX))
      return POS_W'(code) + POS_W'(LOW_BIAS);
    else
      return POS_W'(code) + POS_W'(HIGH_BIAS);
  endfunction

  function automatic logic code_legal(logic [CODE_W-1:0] code);
    return code <= CODE_W'(CODE_MAX);
  endfunction

endpackage

// File: rtl/scatter_code_store.sv
module scatter_code_store
  import addr_scatter_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    wr_sel,
  input  logic [MAP_W-1:0]                    wr_data,
  output logic [NUM_FIELDS-1:0][CODE_W-1:0]   code_q
);

  // Only the coded fields are kept; the rest of each word is dropped.
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int WSEL = field_word(f);
    localparam int HI   = MAP_W - 1 - field_start(f);
    logic [CODE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && wr_sel == SEL_W'(WSEL))
        q <= wr_data[HI -: CODE_W];
    end
    assign code_q[f] = q;
  end

endmodule

// File: rtl/scatter_lane.sv
module scatter_lane
  import addr_scatter_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  input  logic               enable,
  input  logic               data_bit,
  output logic [HADDR_W-1:0] contrib,
  output logic               illegal
);

  logic             legal;
  logic [POS_W-1:0] pos;

  assign legal   = code_legal(code);
  assign pos     = code_to_pos(code);
  assign illegal = enable & ~legal;
  assign contrib = (enable && legal && data_bit) ? (HADDR_W'(1) << pos) : '0;

endmodule

// File: rtl/addr_scatter.sv
module addr_scatter
  import addr_scatter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 map_wr_en,
  input  logic [SEL_W-1:0]     map_wr_sel,
  input  logic [MAP_W-1:0]     map_wr_data,
  input  logic [CNT_W-1:0]     cnt_mrank,
  input  logic [CNT_W-1:0]     cnt_srank,
  input  logic [CNT_W-1:0]     cnt_xrow,
  input  logic                 two_dimm,
  input  logic                 req_valid,
  input  logic                 req_dimm,
  input  logic [MRANK_W-1:0]   req_mrank,
  input  logic [SRANK_W-1:0]   req_srank,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic [BANK_W-1:0]    req_bank,
  output logic                 out_valid,
  output logic                 out_err,
  output logic [HADDR_W-1:0]   out_addr
);

  logic [NUM_FIELDS-1:0][CODE_W-1:0]  code_q;
  logic [NUM_FIELDS-1:0]              fld_en;
  logic [NUM_FIELDS-1:0]              fld_bit;
  logic [NUM_FIELDS-1:0]              fld_bad;
  logic [NUM_FIELDS-1:0][HADDR_W-1:0] fld_contrib;
  logic [HADDR_W-1:0]                 scatter_word;
  logic                               map_err;
  logic                               req_ok;
  logic                               req_bad;

  // Bank bit 2 never takes part
  logic unused_bank_b2;
  assign unused_bank_b2 = req_bank[2];

  scatter_code_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr_en),
    .wr_sel  (map_wr_sel),
    .wr_data (map_wr_data),
    .code_q  (code_q)
  );

  // Source bit of every lane
  always_comb begin
    fld_bit          = '0;
    fld_bit[F_DIMM]  = req_dimm;
    fld_bit[F_M0]    = req_mrank[1];
    fld_bit[F_M1]    = req_mrank[0];
    fld_bit[F_R17]   = req_row[17];
    fld_bit[F_R16]   = req_row[16];
    fld_bit[F_R15]   = req_row[15];
    fld_bit[F_S0]    = req_srank[2];
    fld_bit[F_S1]    = req_srank[1];
    fld_bit[F_S2]    = req_srank[0];
    for (int c = 0; c < COL_W; c++)
      fld_bit[F_C3 + c] = req_col[c];
    fld_bit[F_B0]    = req_bank[4];
    fld_bit[F_B1]    = req_bank[3];
    fld_bit[F_BG0]   = req_bank[1];
    fld_bit[F_BG1]   = req_bank[0];
  end

  // Enables cascade from the configured counts
  always_comb begin
    fld_en         = '1;
    fld_en[F_DIMM] = two_dimm;
    fld_en[F_M0]   = cnt_mrank >= CNT_W'(2);
    fld_en[F_M1]   = cnt_mrank >= CNT_W'(1);
    fld_en[F_R17]  = cnt_xrow  >= CNT_W'(3);
    fld_en[F_R16]  = cnt_xrow  >= CNT_W'(2);
    fld_en[F_R15]  = cnt_xrow  >= CNT_W'(1);
    fld_en[F_S0]   = cnt_srank >= CNT_W'(3);
    fld_en[F_S1]   = cnt_srank >= CNT_W'(2);
    fld_en[F_S2]   = cnt_srank >= CNT_W'(1);
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_lane
    scatter_lane u_lane (
      .code     (code_q[f]),
      .enable   (fld_en[f]),
      .data_bit (fld_bit[f]),
      .contrib  (fld_contrib[f]),
      .illegal  (fld_bad[f])
    );
  end

  always_comb begin
    scatter_word = '0;
    scatter_word[ROW_DIRECT_LSB +: ROW_DIRECT_W] = req_row[ROW_DIRECT_W-1:0];
    for (int f = 0; f < NUM_FIELDS; f++)
      scatter_word = scatter_word | fld_contrib[f];
  end

  assign map_err = |fld_bad;
  assign req_ok  = req_valid & ~map_err;
  assign req_bad = req_valid & map_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_ok;
      out_err   <= req_bad;
      if (req_valid)
        out_addr <= map_err ? '0 : scatter_word;
    end
  end

endmodule

// File: rtl/addr_scatter_props.sv
module addr_scatter_props
  import addr_scatter_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               map_err,
  input logic               out_valid,
  input logic               out_err,
  input logic [HADDR_W-1:0] out_addr,
  input logic [ROW_W-1:0]   req_row
);

  p_accept_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !map_err) |=> (out_valid && !out_err));

  p_reject_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && map_err) |=> (out_err && !out_valid && out_addr == '0));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_err));

  p_row_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !map_err) |=>
      out_addr[ROW_DIRECT_LSB +: ROW_DIRECT_W] == $past(req_row[ROW_DIRECT_W-1:0]));

  p_low_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[LOW_BIAS-1:0] == '0);

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_valid, out_err}) <= 1);

endmodule

bind addr_scatter addr_scatter_props i_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .map_err   (map_err),
  .out_valid (out_valid),
  .out_err   (out_err),
  .out_addr  (out_addr),
  .req_row   (req_row)
);

// File: tb/test_addr_scatter.sv
`timescale 1ns/1ps
module test_addr_scatter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_wr_en = 1'b0;
  logic [1:0]  map_wr_sel = '0;
  logic [63:0] map_wr_data = '0;
  logic [1:0]  cm = '0, cs = '0, cx = '0;
  logic        td = 1'b0;
  logic        req_valid = 1'b0;
  logic        i_dimm = 1'b0;
  logic [1:0]  i_mr = '0;
  logic [2:0]  i_sr = '0;
  logic [17:0] i_row = '0;
  logic [6:0]  i_col = '0;
  logic [4:0]  i_bank = '0;
  logic        out_valid, out_err;
  logic [39:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] sh [3];
  logic [63:0] nx [3];
  logic [31:0] seed = 32'h1badf00d;

  always #4 clk = ~clk;

  addr_scatter i_addr_scatter (
    .clk(clk), .rst_n(rst_n),
    .map_wr_en(map_wr_en), .map_wr_sel(map_wr_sel), .map_wr_data(map_wr_data),
    .cnt_mrank(cm), .cnt_srank(cs), .cnt_xrow(cx), .two_dimm(td),
    .req_valid(req_valid), .req_dimm(i_dimm), .req_mrank(i_mr), .req_srank(i_sr),
    .req_row(i_row), .req_col(i_col), .req_bank(i_bank),
    .out_valid(out_valid), .out_err(out_err), .out_addr(out_addr)
  );

  // Field layout from R3: word and MSB-first start bit of each lane
  function automatic int fw(int f);
    return (f < 6) ? 0 : (f < 14) ? 1 : 2;
  endfunction
  function automatic int fs(int f);
    int t [20] = '{33, 38, 43, 49, 54, 59, 3, 11, 19, 30, 35, 43, 51, 59,
                   3, 11, 19, 27, 43, 51};
    return t[f];
  endfunction
  // Code decode from R1
  function automatic int cpos(int k);
    if (k < 11) return k + 5;
    return k + 20;
  endfunction
  // Enables from R4, R5, R6
  function automatic bit fen(int f);
    case (f)
      0: return td;
      1: return cm > 1;
      2: return cm > 0;
      3: return cx > 2;
      4: return cx > 1;
      5: return cx > 0;
      6: return cs > 2;
      7: return cs > 1;
      8: return cs > 0;
      default: return 1'b1;
    endcase
  endfunction
  // Input bit orderings from R4, R5, R7
  function automatic bit fbit(int f);
    if (f == 0) return i_dimm;
    if (f < 3)  return i_mr[2 - f];
    if (f < 6)  return i_row[20 - f];
    if (f < 9)  return i_sr[8 - f];
    if (f < 16) return i_col[f - 9];
    case (f)
      16: return i_bank[4];
      17: return i_bank[3];
      18: return i_bank[1];
      default: return i_bank[0];
    endcase
  endfunction

  function automatic logic [41:0] model();
    logic [39:0] a;
    bit e;
    a = '0;
    e = 1'b0;
    a[30:16] = i_row[14:0];
    for (int f = 0; f < 20; f++) begin
      int k;
      k = int'(sh[fw(f)][63 - fs(f) -: 5]);
      if (fen(f)) begin
        if (k > 19) e = 1'b1;
        else if (fbit(f)) a[cpos(k)] = 1'b1;
      end
    end
    return e ? {2'b01, 40'd0} : {2'b10, a};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic roll(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic clear_in();
    i_dimm = 0; i_mr = 0; i_sr = 0; i_row = 0; i_col = 0; i_bank = 0;
  endtask

  task automatic set_one(input int f);
    clear_in();
    if (f == 0) i_dimm = 1;
    else if (f < 3)  i_mr[2 - f] = 1;
    else if (f < 6)  i_row[20 - f] = 1;
    else if (f < 9)  i_sr[8 - f] = 1;
    else if (f < 16) i_col[f - 9] = 1;
    else if (f == 16) i_bank[4] = 1;
    else if (f == 17) i_bank[3] = 1;
    else if (f == 18) i_bank[1] = 1;
    else i_bank[0] = 1;
  endtask

  task automatic put_code(input int f, input int k);
    nx[fw(f)][63 - fs(f) -: 5] = 5'(k);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    map_wr_en = 1; map_wr_sel = sel; map_wr_data = d;
    @(negedge clk);
    map_wr_en = 0;
    if (sel < 3) sh[sel] = d;
  endtask

  task automatic commit();
    for (int w = 0; w < 3; w++) wr(2'(w), nx[w]);
  endtask

  task automatic send(input string tag, input logic [41:0] exp);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(tag, {22'd0, out_valid, out_err, out_addr}, {22'd0, exp});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R12 outputs after reset", {22'd0, out_valid, out_err, out_addr}, 64'd0);
    clear_in(); i_col = 7'h01;
    send("R12 cleared codes place C3 at bit 5", {2'b10, 40'h20});
  endtask

  task automatic t_code_space();
    clear_in(); i_col = 7'h01;
    for (int k = 0; k < 20; k++) begin
      put_code(F_C3_IDX, k);
      commit();
      send($sformatf("R1 code %0d", k), {2'b10, 40'd1 << cpos(k)});
    end
  endtask

  localparam int F_C3_IDX = 9;

  task automatic t_fields();
    for (int f = 0; f < 20; f++) put_code(f, f);
    nx[2][63 - 35 -: 5] = 5'd31;
    commit();
    cm = 2; cs = 3; cx = 3; td = 1;
    for (int f = 0; f < 20; f++) begin
      set_one(f);
      send($sformatf("R3 lane %0d", f), {2'b10, 40'd1 << cpos(f)});
    end
    clear_in(); i_bank = 5'b00100;
    send("R7 B2 input and field ignored", {2'b10, 40'd0});
  endtask

  task automatic t_row();
    logic [17:0] pats [3] = '{18'h3FFFF, 18'h2AAAA, 18'h1D5C3};
    cx = 0;
    for (int p = 0; p < 3; p++) begin
      clear_in(); i_row = pats[p];
      send($sformatf("R2 row %h", pats[p]), {2'b10, 40'(pats[p][14:0]) << 16});
    end
  endtask

  task automatic t_cascades();
    logic [39:0] e;
    clear_in(); i_mr = 2'b11;
    for (int n = 0; n < 3; n++) begin
      cm = 2'(n);
      e = '0;
      if (n > 0) e[cpos(2)] = 1;
      if (n > 1) e[cpos(1)] = 1;
      send($sformatf("R4 master count %0d", n), {2'b10, e});
    end
    clear_in(); i_sr = 3'b111;
    for (int n = 0; n < 4; n++) begin
      cs = 2'(n);
      e = '0;
      if (n > 0) e[cpos(8)] = 1;
      if (n > 1) e[cpos(7)] = 1;
      if (n > 2) e[cpos(6)] = 1;
      send($sformatf("R5 slave count %0d", n), {2'b10, e});
    end
    clear_in(); i_row = 18'h38000;
    for (int n = 0; n < 4; n++) begin
      cx = 2'(n);
      e = '0;
      if (n > 0) e[cpos(5)] = 1;
      if (n > 1) e[cpos(4)] = 1;
      if (n > 2) e[cpos(3)] = 1;
      send($sformatf("R5 extra row count %0d", n), {2'b10, e});
    end
    clear_in(); i_dimm = 1;
    td = 0;
    send("R6 dimm flag low", {2'b10, 40'd0});
    td = 1;
    send("R6 dimm flag high", {2'b10, 40'd1 << cpos(0)});
  endtask

  task automatic t_illegal();
    clear_in(); i_col = 7'h7F;
    put_code(11, 25);
    commit();
    send("R9 enabled illegal code", {2'b01, 40'd0});
    put_code(11, 11);
    put_code(1, 28);
    commit();
    cm = 1;
    send("R9 illegal code in disabled lane", model());
    check("R9 disabled lane stays valid", {63'd0, out_valid}, 64'd1);
    cm = 2;
    send("R9 illegal code once lane enabled", {2'b01, 40'd0});
    put_code(1, 1);
    commit();
  endtask

  task automatic t_cfg_timing();
    logic [41:0] e_old, e_new;
    logic [63:0] d;
    clear_in(); i_col = 7'h01;
    d = sh[1];
    d[63 - 30 -: 5] = 5'd17;
    e_old = model();
    map_wr_en = 1; map_wr_sel = 1; map_wr_data = d; req_valid = 1;
    @(negedge clk);
    map_wr_en = 0; req_valid = 0;
    sh[1] = d;
    check("R11 same-cycle write uses old map", {22'd0, out_valid, out_err, out_addr}, {22'd0, e_old});
    e_new = model();
    send("R11 next request uses new map", e_new);
    check("R11 new C3 position", {24'd0, out_addr}, {24'd0, 40'd1 << cpos(17)});
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    send("R11 select 3 ignored", model());
  endtask

  task automatic t_random();
    logic [31:0] v;
    for (int it = 0; it < 40; it++) begin
      for (int f = 0; f < 20; f++) begin
        roll(v);
        put_code(f, int'(v % 20));
      end
      commit();
      roll(v);
      cm = v[1:0] % 3; cs = v[3:2]; cx = v[5:4]; td = v[6];
      roll(v); i_row = v[17:0]; i_col = v[24:18]; i_bank = v[29:25];
      roll(v); i_dimm = v[0]; i_mr = v[2:1]; i_sr = v[5:3];
      send($sformatf("R8 random merge %0d", it), model());
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R10 no request gives quiet outputs", {62'd0, out_valid, out_err}, 64'd0);
  endtask

  initial begin
    for (int w = 0; w < 3; w++) begin
      sh[w] = '0;
      nx[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_code_space();
    t_fields();
    t_row();
    t_cascades();
    t_illegal();
    t_cfg_timing();
    t_random();
    t_idle();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule